// File: doc/BRIEF.md
# Minimum-Delta Coordinate Filter

This block reduces a burst of noisy touch-panel samples to a single steady X/Y coordinate. Two channels, X and Y, run side by side. Each accepted beat carries one sample pair. For each channel the block keeps the last sample it saw and the smallest absolute step between neighbouring samples so far. Whenever a strictly smaller step appears, the current sample becomes that channel's chosen value. The block does not average. The sample that moved least from its predecessor wins.

A burst opens with a `start` pulse that also carries the burst length C. The first C−1 accepted pairs are filtered. The C-th pair closes the burst without being filtered; it is kept for another consumer. One cycle after that closing beat, the block presents the chosen X and Y values with a one-cycle `done` pulse. The outputs then hold until the next `done`.

Top module: `mindelta_filter`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `done` = 0 and `out_x` = `out_y` = 0.
- R2: Only bits [11:0] of `in_x` and `in_y` affect the result. Bits above bit 11 are ignored.
- R3: `start` sets each channel's stored previous sample and stored minimum step to all ones over 13 bits (8191), and sets its chosen value to 0. A channel that never sees a strictly smaller step reports 0. A first sample of 0 therefore gives a step of 8191 and is not an update.
- R4: The step is the absolute difference between the current and the previous sample. The chosen value and the stored minimum change only when the step is strictly below the stored minimum. On a tie the earlier choice stays.
- R5: Every filtered beat loads the previous-sample register with the current sample, whether or not the chosen value changed.
- R6: The X and Y channels have separate registers and never influence each other.
- R7: In a burst of length C, the first C−1 accepted beats are filtered and the C-th accepted beat ends the burst without being filtered. A C of 0 or 1 makes the first accepted beat the closing one.
- R8: `done` is high for exactly one cycle, in the cycle after the closing beat. `out_x`/`out_y` are loaded in that same cycle and hold their value until the next `done`.
- R9: A beat is accepted only when `in_valid` is high, a burst is open and `start` is low. Beats outside a burst, idle cycles inside a burst, and a beat given in the same cycle as `start` are neither counted nor filtered.
- R10: A `start` during an open burst abandons it and begins a new burst with the new length and cleared registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a burst and clears the channel state |
| burst_len | input | CNT_W | Burst length C, sampled with `start` |
| in_valid | input | 1 | A sample pair is present |
| in_x | input | WORD_W | X sample word; the low 12 bits are used |
| in_y | input | WORD_W | Y sample word; the low 12 bits are used |
| done | output | 1 | One-cycle pulse after the closing beat |
| out_x | output | COORD_W | Chosen X coordinate |
| out_y | output | COORD_W | Chosen Y coordinate |

## Verification
The properties assume that `rst` is held for at least one edge at time zero. They also assume that a new closing beat always needs a fresh `start` and at least one further cycle, so `done` can never be high on two cycles in a row. The bench drives every input at the falling edge, releases `start` after one cycle, and gives each burst a fresh `start`. This keeps the stimulus inside those assumptions. The bench still covers gaps in `in_valid`, stray beats outside a burst, a beat in the same cycle as `start`, and a restart while a burst is open.

// File: rtl/mindelta_pkg.sv
package mindelta_pkg;
  localparam int unsigned CHANNELS = 2;
  typedef enum logic [0:0] {CH_X = 1'b0, CH_Y = 1'b1} chan_e;
endpackage

// File: rtl/mindelta_lane.sv
module mindelta_lane #(
  parameter int unsigned COORD_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               step,
  input  logic [COORD_W-1:0] sample,
  output logic [COORD_W-1:0] chosen
);
  // One extra bit so that the all-ones seed sits above every real sample.
  localparam int unsigned EXT_W = COORD_W + 1;

  logic [EXT_W-1:0] prev_q;
  logic [EXT_W-1:0] min_q;
  logic [EXT_W-1:0] cur_ext;
  logic [EXT_W-1:0] delta;

  assign cur_ext = {1'b0, sample};

  always_comb begin
    if (cur_ext >= prev_q) delta = cur_ext - prev_q;
    else                   delta = prev_q - cur_ext;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      prev_q <= '1;
      min_q  <= '1;
      chosen <= '0;
    end else if (step) begin
      prev_q <= cur_ext;
      if (delta < min_q) begin
        min_q  <= delta;
        chosen <= sample;
      end
    end
  end
endmodule

// File: rtl/mindelta_ctl.sv
module mindelta_ctl #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] burst_len,
  input  logic             in_valid,
  output logic             active,
  output logic             step,
  output logic             last_beat
);
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] idx_q;
  logic             take;
  logic [CNT_W:0]   idx_next;

  assign take      = active && in_valid && !start;
  assign idx_next  = {1'b0, idx_q} + 1'b1;
  assign last_beat = take && (idx_next >= {1'b0, len_q});
  assign step      = take && !last_beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      len_q  <= '0;
      idx_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      len_q  <= burst_len;
      idx_q  <= '0;
    end else if (take) begin
      if (last_beat) active <= 1'b0;
      else           idx_q  <= idx_next[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/mindelta_filter.sv
module mindelta_filter #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned COORD_W = 12,
  parameter int unsigned CNT_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [CNT_W-1:0]   burst_len,
  input  logic               in_valid,
  input  logic [WORD_W-1:0]  in_x,
  input  logic [WORD_W-1:0]  in_y,
  output logic               done,
  output logic [COORD_W-1:0] out_x,
  output logic [COORD_W-1:0] out_y
);
  import mindelta_pkg::*;

  logic burst_on;
  logic step;
  logic last_beat;
  logic [COORD_W-1:0] lane_in  [CHANNELS];
  logic [COORD_W-1:0] lane_sel [CHANNELS];

  assign lane_in[CH_X] = in_x[COORD_W-1:0];
  assign lane_in[CH_Y] = in_y[COORD_W-1:0];

  mindelta_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .burst_len (burst_len),
    .in_valid  (in_valid),
    .active    (burst_on),
    .step      (step),
    .last_beat (last_beat)
  );

  for (genvar g = 0; g < CHANNELS; g++) begin : g_lane
    mindelta_lane #(.COORD_W(COORD_W)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .clear  (start),
      .step   (step),
      .sample (lane_in[g]),
      .chosen (lane_sel[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      out_x <= '0;
      out_y <= '0;
    end else begin
      done <= last_beat;
      if (last_beat) begin
        out_x <= lane_sel[CH_X];
        out_y <= lane_sel[CH_Y];
      end
    end
  end
endmodule

// File: rtl/mindelta_checker.sv
module mindelta_checker #(
  parameter int unsigned COORD_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               in_valid,
  input logic               burst_on,
  input logic               done,
  input logic [COORD_W-1:0] out_x,
  input logic [COORD_W-1:0] out_y
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!done && out_x == '0 && out_y == '0));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(out_x) && $stable(out_y)));

  assert_done_after_beat_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(in_valid) && !$past(start)));

  assert_done_needs_burst_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(burst_on));
endmodule

bind mindelta_filter mindelta_checker #(.COORD_W(COORD_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .in_valid (in_valid),
  .burst_on (burst_on),
  .done     (done),
  .out_x    (out_x),
  .out_y    (out_y)
);

// File: tb/sim_mindelta_filter.sv
module sim_mindelta_filter;
  localparam int WORD_W = 16;
  localparam int COORD_W = 12;
  localparam int CNT_W = 8;
  localparam int NV = 4;
  localparam int NB = 5;

  // Each burst has length 5: four filtered pairs, then the closing pair.
  localparam logic [15:0] VX [NV][NB] = '{
    '{16'd100, 16'd110, 16'd105, 16'd300, 16'd300},
    '{16'd10,  16'd20,  16'd30,  16'd40,  16'd40},
    '{16'hF123, 16'hA125, 16'h5124, 16'h0FFF, 16'h0FFF},
    '{16'd0,   16'd4095, 16'd4095, 16'd4000, 16'd4000}};
  localparam logic [15:0] VY [NV][NB] = '{
    '{16'd2000, 16'd2000, 16'd2003, 16'd1999, 16'd1999},
    '{16'd4095, 16'd0,    16'd4095, 16'd0,    16'd0},
    '{16'h8001, 16'h0001, 16'hE002, 16'h0010, 16'h0010},
    '{16'd500,  16'd400,  16'd350,  16'd325,  16'd325}};
  localparam logic [11:0] EX [NV] = '{12'd105, 12'd20, 12'h124, 12'd4095};
  localparam logic [11:0] EY [NV] = '{12'd2000, 12'd0, 12'h001, 12'd325};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CNT_W-1:0] burst_len = '0;
  logic in_valid = 1'b0;
  logic [WORD_W-1:0] in_x = '0;
  logic [WORD_W-1:0] in_y = '0;
  logic done;
  logic [COORD_W-1:0] out_x, out_y;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  mindelta_filter #(.WORD_W(WORD_W), .COORD_W(COORD_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .burst_len(burst_len),
    .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .done(done), .out_x(out_x), .out_y(out_y));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic open_burst(input int len);
    @(negedge clk);
    start = 1'b1;
    burst_len = CNT_W'(len);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Returns at the falling edge after the beat's clock edge.
  task automatic beat(input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    in_valid = 1'b1;
    in_x = x;
    in_y = y;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 done after reset", int'(done), 0);
    chk("R1 out_x after reset", int'(out_x), 0);
    chk("R1 out_y after reset", int'(out_y), 0);
    rst = 1'b0;

    // Table of bursts; covers R2, R4, R5, R6 and the tie rule.
    for (int v = 0; v < NV; v++) begin
      open_burst(NB);
      for (int b = 0; b < NB; b++) begin
        beat(VX[v][b], VY[v][b]);
        if (b < NB - 1) chk("R7 no done before closing beat", int'(done), 0);
      end
      chk($sformatf("R8 done vector %0d", v), int'(done), 1);
      chk($sformatf("R4 R5 R2 out_x vector %0d", v), int'(out_x), int'(EX[v]));
      chk($sformatf("R6 R4 out_y vector %0d", v), int'(out_y), int'(EY[v]));
      @(negedge clk);
      chk("R8 done single pulse", int'(done), 0);
      chk("R8 out_x holds", int'(out_x), int'(EX[v]));
    end

    // R7: length 1, the first beat closes the burst; R3: nothing chosen gives 0.
    open_burst(1);
    beat(16'h0AB, 16'h0CD);
    chk("R7 length-1 done", int'(done), 1);
    chk("R3 length-1 out_x", int'(out_x), 0);
    chk("R3 length-1 out_y", int'(out_y), 0);

    // R9: a stray beat outside a burst is ignored.
    beat(16'd7, 16'd7);
    chk("R9 stray beat no done", int'(done), 0);
    chk("R9 stray beat out_x kept", int'(out_x), 0);
    // R3: a first sample of 0 gives step 8191 and is no update.
    open_burst(2);
    beat(16'd0, 16'd5);
    chk("R7 length-2 not closed", int'(done), 0);
    beat(16'd9, 16'd9);
    chk("R7 length-2 done", int'(done), 1);
    chk("R3 zero first sample out_x", int'(out_x), 0);
    chk("R3 out_y", int'(out_y), 5);

    // R9: idle cycles inside a burst do not count.
    open_burst(3);
    beat(16'd50, 16'd60);
    repeat (3) begin
      @(negedge clk);
      chk("R9 idle gap no done", int'(done), 0);
    end
    beat(16'd52, 16'd61);
    chk("R9 gap burst not closed", int'(done), 0);
    beat(16'd52, 16'd61);
    chk("R9 gap burst done", int'(done), 1);
    chk("R9 gap out_x", int'(out_x), 52);
    chk("R9 gap out_y", int'(out_y), 61);

    // R9: a beat given with start is not accepted.
    @(negedge clk);
    start = 1'b1;
    burst_len = CNT_W'(2);
    in_valid = 1'b1;
    in_x = 16'd1000;
    in_y = 16'd1000;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    in_valid = 1'b0;
    chk("R9 beat with start no done", int'(done), 0);
    beat(16'd200, 16'd300);
    chk("R9 start-beat burst not closed", int'(done), 0);
    beat(16'd0, 16'd0);
    chk("R9 start-beat done", int'(done), 1);
    chk("R9 start-beat out_x", int'(out_x), 200);
    chk("R9 start-beat out_y", int'(out_y), 300);

    // R10: a restart during a burst discards it.
    open_burst(4);
    beat(16'd10, 16'd10);
    beat(16'd11, 16'd11);
    open_burst(2);
    beat(16'd3000, 16'd3001);
    chk("R10 restarted burst not closed", int'(done), 0);
    beat(16'd1, 16'd1);
    chk("R10 restarted done", int'(done), 1);
    chk("R10 out_x", int'(out_x), 3000);
    chk("R10 out_y", int'(out_y), 3001);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule